// File: doc/BRIEF.md
# Hardware Breakpoint Comparator Unit

This block watches the bus activity of a processor core on behalf of a debug host. It compares the instruction fetch address and the data access address against two programmable address registers. When a qualified access matches, it raises a halt request in the same cycle as the access strobe. It also records the hit in sticky pending bits, which the debug host clears later.

Each of the two addresses can act as a breakpoint or a watchpoint. A control register picks which kinds of access are considered: data reads, data writes, or instruction fetches. It can also turn on a range mode, in which any access lying between the two addresses, bounds included, counts as a hit. Range support is chosen when the block is built. When it is left out, the range control bit always reads as zero. The debug host writes and reads the registers through a simple select/data port.

Top module: `hbp_unit`

## Requirements
- R1: After reset the control register, both address registers and both pending bits read as zero, and the halt request is low.
- R2: With control bit 3 (fetch enable) set, outside range mode, a fetch strobe whose address equals address register 0 or address register 1 drives the halt request high in the same cycle.
- R3: With control bit 2 (data enable) set, a data read matches only when control bit 0 is set, and a data write matches only when control bit 1 is set. A matching data access raises the halt request in the same cycle.
- R4: When control bit 2 is clear, data reads and writes never raise the halt request, whatever the state of bits 0 and 1.
- R5: With control bit 4 (range mode) set, an enabled access hits when address register 0 <= access address <= address register 1. Both bounds are included. Nothing matches when register 0 is above register 1.
- R6: Pending bit 0 is set by a hit on address register 0 or by a range hit. Pending bit 1 is set by an exact hit on address register 1. Each bit shows its value after the clock edge that ends the hit cycle, and stays set until it is cleared.
- R7: Writing the status register (select 3) clears each pending bit whose write-data bit is 1 and leaves the others alone. A hit in the same cycle as the clear keeps its bit set.
- R8: Register select codes are 0 for control, 1 for address 0, 2 for address 1 and 3 for status. Control keeps write-data bits 4:0 and reads zero above bit 4. Status reads the pending bits in bits 1:0. A write is visible on the read port after the clock edge that takes it.
- R9: When range support is excluded at build time (RANGE_EN = 0), control bit 4 reads as zero and the unit always compares exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_addr | input | ADDR_W | Instruction fetch address |
| fetch_stb | input | 1 | Instruction fetch strobe |
| data_addr | input | ADDR_W | Data access address |
| data_rd | input | 1 | Data read strobe |
| data_wr | input | 1 | Data write strobe |
| reg_wr | input | 1 | Debug register write enable |
| reg_wsel | input | 2 | Debug register write select |
| reg_wdata | input | ADDR_W | Debug register write data |
| reg_rsel | input | 2 | Debug register read select |
| reg_rdata | output | ADDR_W | Debug register read data |
| halt_req | output | 1 | Halt request, combinational from the matching strobe |
| pend | output | 2 | Sticky pending bits (bit 0: address 0 or range, bit 1: address 1) |

## Verification
The halt request is due in the same cycle as the strobe. The bench drives inputs on the falling edge and compares the halt request one nanosecond before the next rising edge. Pending bits and register readback are due one edge later. The bench model applies the hit or write at that edge and compares the new values during the following cycle, before further stimulus can move them. A second instance built without range support runs on the same stimulus, so the forced-off range bit is checked cycle by cycle against its own expectation.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    localparam int CTL_W  = 5;
    localparam int PEND_W = 2;

    // Control field layout, LSB first: read qual, write qual, data enable,
    // fetch enable, range mode.
    typedef struct packed {
        logic rng;
        logic fetch_en;
        logic data_en;
        logic wr_en;
        logic rd_en;
    } hbp_ctl_t;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_ADR0 = 2'd1,
        SEL_ADR1 = 2'd2,
        SEL_STAT = 2'd3
    } hbp_sel_e;

endpackage

// File: rtl/hbp_match.sv
module hbp_match #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              active,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic              rng,
    output logic              hit0,
    output logic              hit1
);

    always_comb begin
        if (rng) begin
            hit0 = active && (lo <= addr) && (addr <= hi);
            hit1 = 1'b0;
        end else begin
            hit0 = active && (addr == lo);
            hit1 = active && (addr == hi);
        end
    end

endmodule

// File: rtl/hbp_regs.sv
module hbp_regs
    import hbp_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int RANGE_EN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        wsel,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [1:0]        rsel,
    input  logic [PEND_W-1:0] hits,
    output hbp_ctl_t          ctl_o,
    output logic [ADDR_W-1:0] adr0_o,
    output logic [ADDR_W-1:0] adr1_o,
    output logic [PEND_W-1:0] pend_o,
    output logic [ADDR_W-1:0] rdata
);

    localparam logic RNG_ON = (RANGE_EN != 0);

    typedef struct packed {
        hbp_ctl_t          ctl;
        logic [ADDR_W-1:0] adr0;
        logic [ADDR_W-1:0] adr1;
        logic [PEND_W-1:0] pend;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (hbp_sel_e'(wsel))
                SEL_CTL: begin
                    st_d.ctl     = hbp_ctl_t'(wdata[CTL_W-1:0]);
                    st_d.ctl.rng = wdata[CTL_W-1] & RNG_ON;
                end
                SEL_ADR0: st_d.adr0 = wdata;
                SEL_ADR1: st_d.adr1 = wdata;
                SEL_STAT: st_d.pend = st_q.pend & ~wdata[PEND_W-1:0];
                default:  st_d = st_q;
            endcase
        end
        // a hit in the same cycle outranks a clear
        st_d.pend = st_d.pend | hits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (hbp_sel_e'(rsel))
            SEL_CTL:  rdata = {{(ADDR_W-CTL_W){1'b0}}, st_q.ctl};
            SEL_ADR0: rdata = st_q.adr0;
            SEL_ADR1: rdata = st_q.adr1;
            default:  rdata = {{(ADDR_W-PEND_W){1'b0}}, st_q.pend};
        endcase
    end

    assign ctl_o  = st_q.ctl;
    assign adr0_o = st_q.adr0;
    assign adr1_o = st_q.adr1;
    assign pend_o = st_q.pend;

    // R7: a pending bit only drops after a status write with that bit set
    for (genvar i = 0; i < PEND_W; i++) begin : g_pend_chk
        a_r7_clear_needs_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_q.pend[i]) |-> $past(wr && wsel == SEL_STAT && wdata[i]));
    end

    // R9: range bit stays low when range support is built out
    a_r9_range_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
        (RANGE_EN == 0) |-> !st_q.ctl.rng);

    // R8: address registers only change through a write to their select
    a_r8_adr0_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr && wsel == SEL_ADR0) |-> $stable(st_q.adr0));

endmodule

// File: rtl/hbp_unit.sv
module hbp_unit
    import hbp_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int RANGE_EN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_stb,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic              reg_wr,
    input  logic [1:0]        reg_wsel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic [1:0]        reg_rsel,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              halt_req,
    output logic [1:0]        pend
);

    localparam int N_SRC = 2;  // source 0: fetch, source 1: data

    hbp_ctl_t          ctl;
    logic [ADDR_W-1:0] adr0, adr1;
    logic [PEND_W-1:0] pend_q;
    logic [ADDR_W-1:0] src_addr [N_SRC];
    logic [N_SRC-1:0]  src_act;
    logic [N_SRC-1:0]  src_hit0, src_hit1;
    logic [PEND_W-1:0] hits;

    always_comb begin
        src_addr[0] = fetch_addr;
        src_addr[1] = data_addr;
        src_act[0]  = fetch_stb && ctl.fetch_en;
        src_act[1]  = ctl.data_en && ((data_rd && ctl.rd_en) || (data_wr && ctl.wr_en));
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        hbp_match #(.ADDR_W(ADDR_W)) u_match (
            .addr   (src_addr[s]),
            .active (src_act[s]),
            .lo     (adr0),
            .hi     (adr1),
            .rng    (ctl.rng),
            .hit0   (src_hit0[s]),
            .hit1   (src_hit1[s])
        );
    end

    assign hits     = {|src_hit1, |src_hit0};
    assign halt_req = |hits;
    assign pend     = pend_q;

    hbp_regs #(.ADDR_W(ADDR_W), .RANGE_EN(RANGE_EN)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .wsel   (reg_wsel),
        .wdata  (reg_wdata),
        .rsel   (reg_rsel),
        .hits   (hits),
        .ctl_o  (ctl),
        .adr0_o (adr0),
        .adr1_o (adr1),
        .pend_o (pend_q),
        .rdata  (reg_rdata)
    );

    // R2/R3: a halt request needs a strobe on some watched bus
    a_r2_halt_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (fetch_stb || data_rd || data_wr));

    // R4: data accesses cannot halt while data breaking is off
    a_r4_data_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.data_en && !fetch_stb) |-> !halt_req);

    // R6: every halt leaves a pending bit behind
    a_r6_halt_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> (pend != 2'b00));

    // R5: range mode never reports through pending bit 1
    a_r5_range_no_pend1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.rng && !$past(pend_q[1])) |-> !pend_q[1] || !$past(ctl.rng));

endmodule

// File: tb/hbp_unit_tb.sv
`timescale 1ns/1ps
module hbp_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fetch_addr = '0, data_addr = '0, reg_wdata = '0;
    logic        fetch_stb = 1'b0, data_rd = 1'b0, data_wr = 1'b0, reg_wr = 1'b0;
    logic [1:0]  reg_wsel = '0, reg_rsel = '0;
    logic [15:0] rdata_m, rdata_n;
    logic        halt_m, halt_n;
    logic [1:0]  pend_m, pend_n;

    int checks = 0, errors = 0;
    bit done = 0;

    // model state
    logic [4:0]  ctl_w = '0;
    logic [15:0] a0 = '0, a1 = '0;
    logic [1:0]  pm = '0, pn = '0;

    always #2 clk = ~clk;

    hbp_unit #(.ADDR_W(16), .RANGE_EN(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_stb(fetch_stb),
        .data_addr(data_addr), .data_rd(data_rd), .data_wr(data_wr),
        .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
        .reg_rsel(reg_rsel), .reg_rdata(rdata_m), .halt_req(halt_m), .pend(pend_m));

    hbp_unit #(.ADDR_W(16), .RANGE_EN(0)) u_dut_nr (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_stb(fetch_stb),
        .data_addr(data_addr), .data_rd(data_rd), .data_wr(data_wr),
        .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
        .reg_rsel(reg_rsel), .reg_rdata(rdata_n), .halt_req(halt_n), .pend(pend_n));

    function automatic logic [1:0] src_hit(logic [4:0] c, logic [15:0] a, logic act);
        logic [1:0] h;
        h = 2'b00;
        if (act) begin
            if (c[4]) h[0] = (a0 <= a) && (a <= a1);
            else begin
                h[0] = (a == a0);
                h[1] = (a == a1);
            end
        end
        return h;
    endfunction

    function automatic logic [1:0] exp_hits(logic [4:0] c);
        logic fa, da;
        fa = fetch_stb && c[3];
        da = c[2] && ((data_rd && c[0]) || (data_wr && c[1]));
        return src_hit(c, fetch_addr, fa) | src_hit(c, data_addr, da);
    endfunction

    function automatic logic [15:0] exp_read();
        case (reg_rsel)
            2'd0:    return {11'b0, ctl_w};
            2'd1:    return a0;
            2'd2:    return a1;
            default: return {14'b0, pm};
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input string tag);
        logic [1:0] hm, hn;
        logic [4:0] cn;
        #1;
        cn = {1'b0, ctl_w[3:0]};
        hm = exp_hits(ctl_w);
        hn = exp_hits(cn);
        chk(tag, "halt", {15'b0, halt_m}, {15'b0, |hm});
        chk(tag, "halt no-range", {15'b0, halt_n}, {15'b0, |hn});
        chk(tag, "pend", {14'b0, pend_m}, {14'b0, pm});
        chk(tag, "pend no-range", {14'b0, pend_n}, {14'b0, pn});
        chk(tag, "rdata", rdata_m, exp_read());
        if (reg_wr) begin
            case (reg_wsel)
                2'd0: ctl_w = reg_wdata[4:0];
                2'd1: a0 = reg_wdata;
                2'd2: a1 = reg_wdata;
                default: begin
                    pm = pm & ~reg_wdata[1:0];
                    pn = pn & ~reg_wdata[1:0];
                end
            endcase
        end
        pm = pm | hm;
        pn = pn | hn;
        @(posedge clk);
        @(negedge clk);
        fetch_stb = 0; data_rd = 0; data_wr = 0; reg_wr = 0;
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [15:0] d, input string tag);
        reg_wr = 1; reg_wsel = sel; reg_wdata = d;
        cyc(tag);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state on every select
        for (int s = 0; s < 4; s++) begin
            reg_rsel = 2'(s);
            cyc("R1");
        end
        // R8 control keeps five bits, readback one edge later
        reg_rsel = 2'd0;
        wreg(2'd0, 16'hFFFF, "R8");
        cyc("R8");
        wreg(2'd0, 16'h0000, "R8");
        wreg(2'd1, 16'h0010, "R8");
        wreg(2'd2, 16'h0020, "R8");
        // R2 exact fetch
        wreg(2'd0, 16'h0008, "R2");
        reg_rsel = 2'd3;
        fetch_stb = 1; fetch_addr = 16'h0010; cyc("R2");
        fetch_stb = 1; fetch_addr = 16'h0020; cyc("R2");
        fetch_stb = 1; fetch_addr = 16'h0011; cyc("R2");
        fetch_stb = 0; fetch_addr = 16'h0010; cyc("R2");
        wreg(2'd3, 16'h0003, "R7");
        // R4 data disabled
        wreg(2'd0, 16'h0003, "R4");
        data_rd = 1; data_addr = 16'h0010; cyc("R4");
        data_wr = 1; data_addr = 16'h0020; cyc("R4");
        // R3 qualifiers
        wreg(2'd0, 16'h0005, "R3");
        data_rd = 1; data_addr = 16'h0010; cyc("R3");
        data_wr = 1; data_addr = 16'h0020; cyc("R3");
        wreg(2'd0, 16'h0006, "R3");
        data_rd = 1; data_addr = 16'h0020; cyc("R3");
        data_wr = 1; data_addr = 16'h0020; cyc("R3");
        // R6 sticky over idle cycles
        cyc("R6");
        cyc("R6");
        // R7 clear selected bit, then clear racing a hit
        wreg(2'd3, 16'h0001, "R7");
        cyc("R7");
        wreg(2'd0, 16'h0008, "R7");
        fetch_stb = 1; fetch_addr = 16'h0010;
        wreg(2'd3, 16'h0003, "R7");
        cyc("R7");
        wreg(2'd3, 16'h0003, "R7");
        // R5 inclusive range
        wreg(2'd0, 16'h001D, "R5");
        fetch_stb = 1; fetch_addr = 16'h000F; cyc("R5");
        fetch_stb = 1; fetch_addr = 16'h0010; cyc("R5");
        fetch_stb = 1; fetch_addr = 16'h0020; cyc("R5");
        fetch_stb = 1; fetch_addr = 16'h0021; cyc("R5");
        data_rd = 1; data_addr = 16'h001F; cyc("R5");
        // R9 no-range instance compares exactly on the same address
        fetch_stb = 1; fetch_addr = 16'h0018; cyc("R9");
        reg_rsel = 2'd0; cyc("R9");
        wreg(2'd1, 16'h0030, "R5");
        fetch_stb = 1; fetch_addr = 16'h0025; cyc("R5");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            fetch_stb  = ($urandom % 2) == 0;
            fetch_addr = 16'($urandom % 8);
            data_addr  = 16'($urandom % 8);
            data_rd    = ($urandom % 3) == 0;
            data_wr    = ($urandom % 3) == 0;
            reg_rsel   = 2'($urandom % 4);
            if (($urandom % 5) == 0) begin
                reg_wr   = 1;
                reg_wsel = 2'($urandom % 4);
                reg_wdata = (reg_wsel == 2'd1 || reg_wsel == 2'd2) ? 16'($urandom % 8)
                                                                   : 16'($urandom);
            end
            cyc("R3");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule